// File: doc/BRIEF.md
# Buck Switching-Cycle Protection Gate

This block sits between the oscillator of a synchronous step-down converter and its two gate drivers. Once per switching period it decides what the power stage may do. The high-side switch may be allowed to conduct. It may be held off while the low-side switch conducts. Or the switching node may be released to a high-impedance state. Within a period it also ends high-side conduction when the control loop or the current limit asks for it.

Several protections combine in one small state machine. A current-limit trip cuts the on-time at once. A trip seen while the output is collapsed makes the next few periods skip conduction altogether. A long run of trips shuts the stage down, and it then either retries on its own or waits for the enable input to toggle. During long runs of full duty, every eighth period is forced to start with a short off window so the bootstrap supply can recharge. An over-voltage condition is only looked at when a period begins. A thermal fault or a low enable releases the node right away.

The inputs are single-clock pulses or levels that are already synchronous to `clk`. Exactly one of the three outputs is high on every clock, and each one is a registered decode of the drive state.

Top module: `buck_cycle_gate`

## Requirements
- R1: While reset is applied and afterwards, until the first period start, `sw_tristate` is 1 and `hs_on`, `ls_on` are 0.
- R2: A `cyc_start` pulse that nothing blocks puts `hs_on` to 1 on the next clock.
- R3: While `hs_on` is 1, a `pwm_trip` or `ilim_trip` pulse sets `hs_on` to 0 and `ls_on` to 1 on the next clock. A trip on the same clock as `cyc_start` is ignored.
- R4: An `ilim_trip` that ends conduction while `fb_low` is 1 makes the next SKIP_CYCLES (default 4) period starts give `ls_on` for the whole period, with no high-side conduction.
- R5: After BOOT_PERIOD-1 (default 7) consecutive periods that both begin and end with `hs_on`, the next period begins with MIN_OFF_CLKS (default 3) clocks of `ls_on` and then `hs_on`.
- R6: `ov_flag` is sampled only on `cyc_start`. When it is set there, the whole period is tri-stated. When it is set mid-period, the current drive is unchanged.
- R7: `therm_flag` gives `sw_tristate` on the next clock. The node stays tri-stated until the first `cyc_start` seen with the flag clear.
- R8: `enable` low gives `sw_tristate` on the next clock. It also clears the over-current shutdown, the trip tally, the pending skips and the full-duty run.
- R9: OC_LIMIT (default 4) conducting periods in a row that each end with an `ilim_trip` tri-state the node from the next period start. A period with no high-side conduction leaves the tally unchanged. A conducting period without a trip clears it.
- R10: With `latch_mode` 0, a shutdown holds for RETRY_CYCLES (default 6) period starts. Normal operation resumes at the start after those.
- R11: With `latch_mode` 1, a shutdown holds for any number of periods until `enable` goes low.
- R12: On every clock exactly one of `hs_on`, `ls_on`, `sw_tristate` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock pulse at the start of each switching period |
| pwm_trip | input | 1 | Control-loop comparator pulse ending the on-time |
| ilim_trip | input | 1 | High-side current-limit pulse |
| fb_low | input | 1 | Feedback is far below target (hard short) |
| ov_flag | input | 1 | Output above the over-voltage threshold |
| therm_flag | input | 1 | Die temperature above the shutdown limit |
| enable | input | 1 | Regulator enable level |
| latch_mode | input | 1 | 1: over-current shutdown waits for enable toggle; 0: timed retry |
| hs_on | output | 1 | High-side drive enable |
| ls_on | output | 1 | Low-side drive enable |
| sw_tristate | output | 1 | Switching node high-impedance command |

## Verification
Every result of this block appears one clock after the input that causes it. This holds for conduction at a start, the cut after a trip, the release on thermal fault or enable low, and the shutdown at the start after the last trip. The only exception is the refresh window: it holds the low side for MIN_OFF_CLKS clocks after the start, so the high side returns on the clock after that. The bench changes inputs on the falling edge and reads outputs on the next falling edge. Each observation therefore reflects exactly the inputs of the rising edge in between. A clock-by-clock model in the bench, built from the requirements, predicts each sample. Directed periods also check the offsets named above at fixed positions inside a period.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    // Drive state of the power stage; BOOT is a forced low-side window.
    typedef enum logic [1:0] {
        DRV_TRI  = 2'd0,
        DRV_HS   = 2'd1,
        DRV_LS   = 2'd2,
        DRV_BOOT = 2'd3
    } drv_mode_e;

endpackage

// File: rtl/bcg_ocp_guard.sv
module bcg_ocp_guard #(
    parameter int OC_LIMIT     = 4,
    parameter int RETRY_CYCLES = 6,
    parameter int SKIP_CYCLES  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic latch_mode,
    input  logic cyc_start,
    input  logic hs_active,
    input  logic ilim_hit,
    input  logic fb_low,
    output logic oc_block,
    output logic skip_now
);

    localparam int CW = $clog2(OC_LIMIT + 1);
    localparam int RW = $clog2(RETRY_CYCLES + 1);
    localparam int SW = $clog2(SKIP_CYCLES + 1);

    typedef struct packed {
        logic          ran;
        logic          trip;
        logic [CW-1:0] cnt;
        logic          off;
        logic [RW-1:0] retry;
        logic [SW-1:0] skip;
    } ocp_st_t;

    ocp_st_t st_d, st_q;
    logic    ran_now, trip_now;
    logic [CW:0] cnt_next;

    always_comb begin
        st_d     = st_q;
        oc_block = 1'b0;
        skip_now = 1'b0;
        ran_now  = st_q.ran | hs_active;
        trip_now = st_q.trip | ilim_hit;
        cnt_next = {1'b0, st_q.cnt};
        if (!enable) begin
            st_d = '0;
        end else begin
            if (hs_active) st_d.ran = 1'b1;
            if (ilim_hit)  st_d.trip = 1'b1;
            if (ilim_hit && fb_low) st_d.skip = SW'(SKIP_CYCLES);
            if (cyc_start) begin
                // Tally for the period that just ended.
                if (ran_now) begin
                    cnt_next = trip_now ? ({1'b0, st_q.cnt} + 1'b1) : '0;
                end
                st_d.ran  = 1'b0;
                st_d.trip = 1'b0;
                skip_now  = (st_q.skip != '0);
                if (skip_now) st_d.skip = st_q.skip - 1'b1;
                if (st_q.off) begin
                    st_d.cnt = '0;
                    if (!latch_mode && st_q.retry == '0) begin
                        st_d.off = 1'b0;
                    end else begin
                        oc_block = 1'b1;
                        if (st_q.retry != '0) st_d.retry = st_q.retry - 1'b1;
                    end
                end else if (cnt_next >= (CW+1)'(OC_LIMIT)) begin
                    st_d.off   = 1'b1;
                    st_d.retry = RW'(RETRY_CYCLES - 1);
                    st_d.cnt   = '0;
                    oc_block   = 1'b1;
                end else begin
                    st_d.cnt = cnt_next[CW-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_skip_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ilim_hit && fb_low) |=> (st_q.skip == SW'(SKIP_CYCLES)));

    assert_latch_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && latch_mode && st_q.off) |=> st_q.off);

    assert_release_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> (!st_q.off && st_q.skip == '0 && st_q.cnt == '0));

endmodule

// File: rtl/bcg_boot_refresh.sv
module bcg_boot_refresh #(
    parameter int BOOT_PERIOD  = 8,
    parameter int MIN_OFF_CLKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cyc_start,
    input  logic hs_active,
    output logic boot_now,
    output logic win_expire
);

    localparam int RNW = $clog2(BOOT_PERIOD);
    localparam int TW  = $clog2(MIN_OFF_CLKS + 1);

    typedef struct packed {
        logic           full;
        logic [RNW-1:0] run;
        logic [TW-1:0]  tmr;
    } boot_st_t;

    boot_st_t st_d, st_q;
    logic     full_now;

    always_comb begin
        st_d       = st_q;
        boot_now   = 1'b0;
        full_now   = st_q.full & hs_active;
        win_expire = enable && !cyc_start && (st_q.tmr == TW'(1));
        if (!enable) begin
            st_d = '0;
        end else if (cyc_start) begin
            st_d.run  = full_now ? (st_q.run + 1'b1) : '0;
            boot_now  = (st_d.run == RNW'(BOOT_PERIOD - 1));
            st_d.full = 1'b1;
            st_d.tmr  = boot_now ? TW'(MIN_OFF_CLKS) : '0;
        end else begin
            st_d.full = full_now;
            if (st_q.tmr != '0) st_d.tmr = st_q.tmr - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_window_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !cyc_start && st_q.tmr != '0) |=> (st_q.tmr == $past(st_q.tmr) - 1'b1));

    assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        boot_now |=> (st_q.tmr == TW'(MIN_OFF_CLKS)));

endmodule

// File: rtl/buck_cycle_gate.sv
module buck_cycle_gate
    import bcg_pkg::*;
#(
    parameter int OC_LIMIT     = 4,
    parameter int RETRY_CYCLES = 6,
    parameter int SKIP_CYCLES  = 4,
    parameter int BOOT_PERIOD  = 8,
    parameter int MIN_OFF_CLKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic pwm_trip,
    input  logic ilim_trip,
    input  logic fb_low,
    input  logic ov_flag,
    input  logic therm_flag,
    input  logic enable,
    input  logic latch_mode,
    output logic hs_on,
    output logic ls_on,
    output logic sw_tristate
);

    typedef struct packed {
        drv_mode_e mode;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     hs_active, ilim_hit;
    logic     oc_block, skip_now, boot_now, win_expire;

    assign hs_active = (st_q.mode == DRV_HS);
    // Trips on the start clock are blanked.
    assign ilim_hit  = hs_active && ilim_trip && !cyc_start;

    bcg_ocp_guard #(
        .OC_LIMIT     (OC_LIMIT),
        .RETRY_CYCLES (RETRY_CYCLES),
        .SKIP_CYCLES  (SKIP_CYCLES)
    ) i_ocp (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .latch_mode (latch_mode),
        .cyc_start  (cyc_start),
        .hs_active  (hs_active),
        .ilim_hit   (ilim_hit),
        .fb_low     (fb_low),
        .oc_block   (oc_block),
        .skip_now   (skip_now)
    );

    bcg_boot_refresh #(
        .BOOT_PERIOD  (BOOT_PERIOD),
        .MIN_OFF_CLKS (MIN_OFF_CLKS)
    ) i_boot (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .cyc_start  (cyc_start),
        .hs_active  (hs_active),
        .boot_now   (boot_now),
        .win_expire (win_expire)
    );

    always_comb begin
        st_d = st_q;
        if (!enable || therm_flag) begin
            st_d.mode = DRV_TRI;
        end else if (cyc_start) begin
            if (ov_flag || oc_block) st_d.mode = DRV_TRI;
            else if (skip_now)       st_d.mode = DRV_LS;
            else if (boot_now)       st_d.mode = DRV_BOOT;
            else                     st_d.mode = DRV_HS;
        end else begin
            unique case (st_q.mode)
                DRV_HS:   if (pwm_trip || ilim_trip) st_d.mode = DRV_LS;
                DRV_BOOT: if (win_expire) st_d.mode = DRV_HS;
                default:  st_d.mode = st_q.mode;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: DRV_TRI};
        else        st_q <= st_d;
    end

    assign hs_on       = (st_q.mode == DRV_HS);
    assign ls_on       = (st_q.mode == DRV_LS) || (st_q.mode == DRV_BOOT);
    assign sw_tristate = (st_q.mode == DRV_TRI);

    assert_trip_cuts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_on && ilim_trip && !cyc_start && enable && !therm_flag) |=> ls_on);

    assert_therm_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        therm_flag |=> sw_tristate);

    assert_enable_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> sw_tristate);

    assert_ov_midcycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_on && ov_flag && !cyc_start && !ilim_trip && !pwm_trip && enable && !therm_flag)
        |=> hs_on);

    assert_oc_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && oc_block && enable) |=> sw_tristate);

endmodule

// File: tb/test_buck_cycle_gate.sv
module test_buck_cycle_gate;

    localparam int OCL    = 4;
    localparam int RET    = 6;
    localparam int SKP    = 4;
    localparam int BP     = 8;
    localparam int MINOFF = 3;
    localparam int PER    = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_start = 0, pwm_trip = 0, ilim_trip = 0, fb_low = 0;
    logic ov_flag = 0, therm_flag = 0, enable = 1, latch_mode = 0;
    logic hs_on, ls_on, sw_tristate;

    int n_chk = 0, n_bad = 0;
    string cur_req = "R1";
    logic [2:0] obs [PER];
    bit done = 0;

    always #2 clk = ~clk;

    buck_cycle_gate #(
        .OC_LIMIT(OCL), .RETRY_CYCLES(RET), .SKIP_CYCLES(SKP),
        .BOOT_PERIOD(BP), .MIN_OFF_CLKS(MINOFF)
    ) i_buck_cycle_gate (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .pwm_trip(pwm_trip),
        .ilim_trip(ilim_trip), .fb_low(fb_low), .ov_flag(ov_flag),
        .therm_flag(therm_flag), .enable(enable), .latch_mode(latch_mode),
        .hs_on(hs_on), .ls_on(ls_on), .sw_tristate(sw_tristate)
    );

    // Reference model: mode 0 tri, 1 high side, 2 low side, 3 refresh window.
    int m_mode, m_ran, m_trip, m_cnt, m_off, m_retry, m_skip, m_full, m_run, m_tmr;

    always @(posedge clk or negedge rst_n) begin : ref_model
        int hs, hit, blk, skp, bt, expw, cnt, run;
        int n_mode, n_ran, n_trip, n_cnt, n_off, n_retry, n_skip, n_full, n_run, n_tmr;
        if (!rst_n) begin
            m_mode = 0; m_ran = 0; m_trip = 0; m_cnt = 0; m_off = 0;
            m_retry = 0; m_skip = 0; m_full = 0; m_run = 0; m_tmr = 0;
        end else begin
            hs   = (m_mode == 1);
            hit  = hs && ilim_trip && !cyc_start;
            expw = (m_tmr == 1) && !cyc_start && enable;
            blk = 0; skp = 0; bt = 0;
            n_mode = m_mode; n_ran = m_ran; n_trip = m_trip; n_cnt = m_cnt;
            n_off = m_off; n_retry = m_retry; n_skip = m_skip;
            n_full = m_full; n_run = m_run; n_tmr = m_tmr;
            if (!enable) begin
                n_ran = 0; n_trip = 0; n_cnt = 0; n_off = 0; n_retry = 0;
                n_skip = 0; n_full = 0; n_run = 0; n_tmr = 0;
            end else begin
                if (hs) n_ran = 1;
                if (hit) n_trip = 1;
                if (hit && fb_low) n_skip = SKP;
                if (cyc_start) begin
                    cnt = (m_ran || hs) ? ((m_trip || hit) ? m_cnt + 1 : 0) : m_cnt;
                    n_ran = 0; n_trip = 0;
                    skp = (m_skip != 0);
                    if (skp) n_skip = m_skip - 1;
                    if (m_off != 0) begin
                        n_cnt = 0;
                        if (!latch_mode && m_retry == 0) n_off = 0;
                        else begin
                            blk = 1;
                            if (m_retry != 0) n_retry = m_retry - 1;
                        end
                    end else if (cnt >= OCL) begin
                        n_off = 1; n_retry = RET - 1; n_cnt = 0; blk = 1;
                    end else n_cnt = cnt;
                    run = (m_full && hs) ? m_run + 1 : 0;
                    bt = (run == BP - 1);
                    n_run = run; n_full = 1; n_tmr = bt ? MINOFF : 0;
                end else begin
                    n_full = m_full && hs;
                    if (m_tmr != 0) n_tmr = m_tmr - 1;
                end
            end
            if (!enable || therm_flag) n_mode = 0;
            else if (cyc_start) begin
                if (ov_flag || blk) n_mode = 0;
                else if (skp) n_mode = 2;
                else if (bt) n_mode = 3;
                else n_mode = 1;
            end else if (m_mode == 1 && (pwm_trip || ilim_trip)) n_mode = 2;
            else if (m_mode == 3 && expw) n_mode = 1;
            m_mode = n_mode; m_ran = n_ran; m_trip = n_trip; m_cnt = n_cnt;
            m_off = n_off; m_retry = n_retry; m_skip = n_skip;
            m_full = n_full; m_run = n_run; m_tmr = n_tmr;
        end
    end

    function automatic logic [2:0] mode_vec(int md);
        case (md)
            0: return 3'b001;
            1: return 3'b100;
            default: return 3'b010;
        endcase
    endfunction

    task automatic chk(bit ok, string req, logic [2:0] act, logic [2:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: {hs,ls,tri} actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Clock-by-clock comparison, called on falling edges.
    task automatic compare();
        logic [2:0] act;
        act = {hs_on, ls_on, sw_tristate};
        chk(act == mode_vec(m_mode), cur_req, act, mode_vec(m_mode));
        chk($countones(act) == 1, "R12", act, mode_vec(m_mode));
    endtask

    // One switching period; obs[k] is the drive after the inputs of index k-1.
    task automatic run_cycle(int pwm_at, int ilim_at, bit fb, int ov_at,
                             int th_lo, int th_hi, int en_lo, int en_hi);
        for (int k = 0; k < PER; k++) begin
            @(negedge clk);
            compare();
            obs[k] = {hs_on, ls_on, sw_tristate};
            cyc_start  = (k == 0);
            pwm_trip   = (k == pwm_at);
            ilim_trip  = (k == ilim_at);
            fb_low     = fb;
            ov_flag    = (k == ov_at);
            therm_flag = (k >= th_lo) && (k <= th_hi);
            enable     = !((k >= en_lo) && (k <= en_hi));
        end
    endtask

    task automatic plain(int pwm_at);
        run_cycle(pwm_at, -1, 1'b0, -1, -1, -1, -1, -1);
    endtask

    localparam logic [2:0] V_HS  = 3'b100;
    localparam logic [2:0] V_LS  = 3'b010;
    localparam logic [2:0] V_TRI = 3'b001;

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk({hs_on, ls_on, sw_tristate} == V_TRI, "R1", {hs_on, ls_on, sw_tristate}, V_TRI);
        rst_n = 1'b1;
        repeat (2) begin
            @(negedge clk);
            compare();
            chk({hs_on, ls_on, sw_tristate} == V_TRI, "R1", {hs_on, ls_on, sw_tristate}, V_TRI);
        end

        // R2: normal period, on-time ended by the loop comparator
        cur_req = "R2";
        plain(6);
        chk(obs[1] == V_HS, "R2", obs[1], V_HS);
        chk(obs[7] == V_LS, "R2", obs[7], V_LS);

        // R3: current-limit cut, and trip blanked on the start clock
        cur_req = "R3";
        run_cycle(-1, 4, 1'b0, -1, -1, -1, -1, -1);
        chk(obs[4] == V_HS, "R3", obs[4], V_HS);
        chk(obs[5] == V_LS, "R3", obs[5], V_LS);
        plain(0);
        chk(obs[2] == V_HS, "R3", obs[2], V_HS);
        plain(6);

        // R4: hard-short trip then skipped periods
        cur_req = "R4";
        run_cycle(-1, 3, 1'b1, -1, -1, -1, -1, -1);
        for (int c = 0; c < SKP; c++) begin
            plain(6);
            chk(obs[1] == V_LS && obs[6] == V_LS, "R4", obs[1], V_LS);
        end
        plain(6);
        chk(obs[1] == V_HS, "R4", obs[1], V_HS);

        // R5: bootstrap refresh after a run of full-duty periods
        cur_req = "R5";
        for (int c = 0; c < BP - 1; c++) begin
            plain(-1);
            chk(obs[1] == V_HS, "R5", obs[1], V_HS);
        end
        plain(-1);
        for (int k = 1; k <= MINOFF; k++) chk(obs[k] == V_LS, "R5", obs[k], V_LS);
        chk(obs[MINOFF + 1] == V_HS, "R5", obs[MINOFF + 1], V_HS);

        // R6: over-voltage mid-period ignored, at start tri-states the period
        cur_req = "R6";
        run_cycle(9, -1, 1'b0, 5, -1, -1, -1, -1);
        chk(obs[7] == V_HS, "R6", obs[7], V_HS);
        run_cycle(6, -1, 1'b0, 0, -1, -1, -1, -1);
        chk(obs[1] == V_TRI && obs[11] == V_TRI, "R6", obs[11], V_TRI);
        plain(6);
        chk(obs[1] == V_HS, "R6", obs[1], V_HS);

        // R7: thermal release held to the next start
        cur_req = "R7";
        run_cycle(-1, -1, 1'b0, -1, 4, 5, -1, -1);
        chk(obs[5] == V_TRI, "R7", obs[5], V_TRI);
        chk(obs[11] == V_TRI, "R7", obs[11], V_TRI);
        plain(6);
        chk(obs[1] == V_HS, "R7", obs[1], V_HS);

        // R9 and R10: sustained trips then timed retry
        cur_req = "R9";
        for (int c = 0; c < OCL; c++) run_cycle(-1, 3, 1'b0, -1, -1, -1, -1, -1);
        cur_req = "R10";
        for (int c = 0; c < RET; c++) begin
            plain(6);
            chk(obs[1] == V_TRI && obs[8] == V_TRI, c == 0 ? "R9" : "R10", obs[1], V_TRI);
        end
        plain(6);
        chk(obs[1] == V_HS, "R10", obs[1], V_HS);

        // R11: latched shutdown; skip periods do not break the tally
        cur_req = "R11";
        latch_mode = 1'b1;
        for (int t = 0; t < OCL; t++) begin
            run_cycle(-1, 3, 1'b1, -1, -1, -1, -1, -1);
            if (t < OCL - 1)
                for (int c = 0; c < SKP; c++) plain(6);
        end
        for (int c = 0; c < RET + 4; c++) begin
            plain(6);
            chk(obs[1] == V_TRI, "R11", obs[1], V_TRI);
        end
        run_cycle(6, -1, 1'b0, -1, -1, -1, 2, 4);
        plain(6);
        chk(obs[1] == V_HS, "R11", obs[1], V_HS);
        latch_mode = 1'b0;

        // R8: enable low during conduction
        cur_req = "R8";
        run_cycle(-1, -1, 1'b0, -1, -1, -1, 4, 6);
        chk(obs[4] == V_HS, "R8", obs[4], V_HS);
        chk(obs[5] == V_TRI, "R8", obs[5], V_TRI);
        plain(6);
        chk(obs[1] == V_HS, "R8", obs[1], V_HS);

        // Random mix against the model
        cur_req = "R12";
        for (int c = 0; c < 1500; c++) begin
            int pa, ia, oa, tl, th, el, eh;
            bit fb;
            if (c % 100 == 0) latch_mode = $urandom % 2;
            pa = ($urandom % 4 == 0) ? -1 : 2 + int'($urandom % 10);
            ia = ($urandom % 5 == 0) ? 1 + int'($urandom % 11) : -1;
            fb = ($urandom % 3 == 0);
            oa = ($urandom % 15 == 0) ? int'($urandom % PER) : -1;
            tl = -1; th = -1; el = -1; eh = -1;
            if ($urandom % 30 == 0) begin tl = $urandom % PER; th = tl + int'($urandom % 4); end
            if ($urandom % 40 == 0) begin el = $urandom % PER; eh = el + int'($urandom % 3); end
            run_cycle(pa, ia, fb, oa, tl, th, el, eh);
        end

        @(negedge clk);
        compare();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule